// File: doc/BRIEF.md
# Fixed-Point Coordinate Scissor Unit

This unit sits in the pixel path of a rasteriser. Each candidate pixel arrives with an X and a Y position in unsigned 12.4 fixed point, so each axis spans 0 to 4095.9375. The unit subtracts a programmable drawing offset from each axis to form window coordinates, drops the fraction, and tests the integer position against an inclusive scissor rectangle. Pixels inside the rectangle leave with 11-bit integer window coordinates. Pixels outside it, or left of or above the offset, are discarded and counted. The offset normally sits near the middle of the space at (2048, 2048), which leaves room for geometry that starts off-screen.

The unit only rejects pixels; it never changes the geometry of a primitive. Streams on both sides use valid/ready. The path is a two-stage pipeline: the first stage subtracts and the second compares. It takes one pixel per cycle, holds its output while backpressured and keeps pixels in order. A small write port loads the offset and the rectangle and clears the drop counter.

Top module: `pix_scissor`

## Requirements
- R1: The window coordinate on each axis is the 17-bit signed difference `{0,input} - {0,offset}`, with input and offset in unsigned 12.4 format. The integer pixel index is bits [15:4] of that difference, so the four fraction bits are truncated. A passed pixel reports bits [10:0] of the index on the output.
- R2: A pixel is dropped when the difference on either axis is negative.
- R3: A pixel is passed only when min_x <= index_x <= max_x and min_y <= index_y <= max_y, with all four bounds inclusive. Otherwise it is dropped, and a rectangle whose minimum exceeds its maximum drops every pixel.
- R4: A write with cfg_we_i=1 sets one register according to cfg_addr_i. Address 0 sets offset X and address 1 sets offset Y, each from cfg_wdata_i[15:0]. Addresses 2, 3, 4 and 5 set min X, max X, min Y and max Y, each from cfg_wdata_i[10:0]. A new value applies to pixels accepted after the write edge.
- R5: After reset both offsets are 16'h8000 (2048.0), both minimum bounds are 0, both maximum bounds are 2047, the drop counter is 0, out_valid_o is 0 and in_ready_o is 1.
- R6: When the output is not stalled, a pixel accepted at clock edge E appears on out_valid_o after edge E+1. Back-to-back pixels pass one per cycle, in the order they were accepted, with no loss or duplication.
- R7: While out_valid_o=1 and out_ready_i=0, out_valid_o, out_x_o and out_y_o hold their values.
- R8: rej_cnt_o adds one for each dropped pixel and saturates at 2^CNT_W-1.
- R9: A write to address 6 clears rej_cnt_o. If a pixel is dropped in the same cycle, the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 16 | Register write data |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Unit can take an input pixel |
| in_x_i | input | 16 | Pixel X, unsigned 12.4 |
| in_y_i | input | 16 | Pixel Y, unsigned 12.4 |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream can take a pixel |
| out_x_o | output | 11 | Window X, integer |
| out_y_o | output | 11 | Window Y, integer |
| rej_cnt_o | output | CNT_W | Saturating count of dropped pixels |

## Verification
The bench drives pixels that land exactly on each rectangle edge and one unit beyond it. These separate inclusive bounds from exclusive ones and catch swapped min/max comparisons. Positions a sixteenth of a pixel below the offset separate a signed compare from an unsigned one, and values with a large fraction separate truncation from rounding. Random pixels sent against random backpressure test order, stalls and throughput against a queue of expected pixels. Long runs of rejected pixels drive the counter to saturation, and writes to address 6 clear it.

// File: rtl/scis_pkg.sv
package scis_pkg;
  typedef enum logic [2:0] {
    REG_OFF_X   = 3'd0,
    REG_OFF_Y   = 3'd1,
    REG_MIN_X   = 3'd2,
    REG_MAX_X   = 3'd3,
    REG_MIN_Y   = 3'd4,
    REG_MAX_Y   = 3'd5,
    REG_CLR_CNT = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/scis_cfg_regs.sv
module scis_cfg_regs
  import scis_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int BOUND_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [COORD_W-1:0] wdata_i,
  output logic [COORD_W-1:0] off_x_o,
  output logic [COORD_W-1:0] off_y_o,
  output logic [BOUND_W-1:0] min_x_o,
  output logic [BOUND_W-1:0] max_x_o,
  output logic [BOUND_W-1:0] min_y_o,
  output logic [BOUND_W-1:0] max_y_o,
  output logic               clr_o
);
  localparam logic [COORD_W-1:0] OFF_RST = COORD_W'(1) << (COORD_W-1);

  reg_addr_e sel;
  assign sel   = reg_addr_e'(addr_i);
  assign clr_o = we_i && (sel == REG_CLR_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_x_o <= OFF_RST;
      off_y_o <= OFF_RST;
      min_x_o <= '0;
      max_x_o <= '1;
      min_y_o <= '0;
      max_y_o <= '1;
    end else if (we_i) begin
      case (sel)
        REG_OFF_X: off_x_o <= wdata_i;
        REG_OFF_Y: off_y_o <= wdata_i;
        REG_MIN_X: min_x_o <= wdata_i[BOUND_W-1:0];
        REG_MAX_X: max_x_o <= wdata_i[BOUND_W-1:0];
        REG_MIN_Y: min_y_o <= wdata_i[BOUND_W-1:0];
        REG_MAX_Y: max_y_o <= wdata_i[BOUND_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scis_sub_stage.sv
module scis_sub_stage #(
  parameter int COORD_W = 16,
  localparam int DIFF_W = COORD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [COORD_W-1:0] in_x_i,
  input  logic [COORD_W-1:0] in_y_i,
  input  logic [COORD_W-1:0] off_x_i,
  input  logic [COORD_W-1:0] off_y_i,
  input  logic               adv_i,
  output logic               s1_valid_o,
  output logic [DIFF_W-1:0]  dx_o,
  output logic [DIFF_W-1:0]  dy_o
);
  logic take;
  assign in_ready_o = !s1_valid_o || adv_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_o <= 1'b0;
      dx_o       <= '0;
      dy_o       <= '0;
    end else if (take) begin
      s1_valid_o <= 1'b1;
      dx_o       <= {1'b0, in_x_i} - {1'b0, off_x_i};
      dy_o       <= {1'b0, in_y_i} - {1'b0, off_y_i};
    end else if (adv_i) begin
      s1_valid_o <= 1'b0;
    end
  end

  p_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> s1_valid_o);
  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_o && !adv_i) |=> (s1_valid_o && $stable(dx_o) && $stable(dy_o)));
endmodule

// File: rtl/scis_cmp_stage.sv
module scis_cmp_stage #(
  parameter int COORD_W = 16,
  parameter int FRAC_W  = 4,
  parameter int BOUND_W = 11,
  localparam int DIFF_W = COORD_W + 1,
  localparam int INT_W  = COORD_W - FRAC_W,
  localparam int PAD_W  = INT_W - BOUND_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               s1_valid_i,
  input  logic [DIFF_W-1:0]  dx_i,
  input  logic [DIFF_W-1:0]  dy_i,
  input  logic [BOUND_W-1:0] min_x_i,
  input  logic [BOUND_W-1:0] max_x_i,
  input  logic [BOUND_W-1:0] min_y_i,
  input  logic [BOUND_W-1:0] max_y_i,
  output logic               adv_o,
  output logic               drop_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [BOUND_W-1:0] out_x_o,
  output logic [BOUND_W-1:0] out_y_o
);
  logic [INT_W-1:0] ix, iy;
  logic             neg, in_x, in_y, hit, s2_ready, load;
  logic             unused_frac;

  assign ix  = dx_i[COORD_W-1:FRAC_W];
  assign iy  = dy_i[COORD_W-1:FRAC_W];
  assign unused_frac = ^{dx_i[FRAC_W-1:0], dy_i[FRAC_W-1:0]};
  assign neg = dx_i[DIFF_W-1] | dy_i[DIFF_W-1];

  assign in_x = (ix >= {{PAD_W{1'b0}}, min_x_i}) && (ix <= {{PAD_W{1'b0}}, max_x_i});
  assign in_y = (iy >= {{PAD_W{1'b0}}, min_y_i}) && (iy <= {{PAD_W{1'b0}}, max_y_i});
  assign hit  = !neg && in_x && in_y;

  assign s2_ready = !out_valid_o || out_ready_i;
  // rejected pixels leave stage 1 without needing room in stage 2
  assign adv_o  = s1_valid_i && (!hit || s2_ready);
  assign drop_o = s1_valid_i && !hit;
  assign load   = s1_valid_i && hit && s2_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_x_o     <= '0;
      out_y_o     <= '0;
    end else if (load) begin
      out_valid_o <= 1'b1;
      out_x_o     <= ix[BOUND_W-1:0];
      out_y_o     <= iy[BOUND_W-1:0];
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_x_o) && $stable(out_y_o)));
  p_x_in_rect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (out_x_o >= $past(min_x_i) && out_x_o <= $past(max_x_i)));
  p_y_in_rect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (out_y_o >= $past(min_y_i) && out_y_o <= $past(max_y_i)));
endmodule

// File: rtl/scis_rej_counter.sv
module scis_rej_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
  end

  p_cnt_mono_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));
  p_cnt_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);
  p_cnt_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o <= CNT_W'(1));
endmodule

// File: rtl/pix_scissor.sv
module pix_scissor #(
  parameter int COORD_W = 16,
  parameter int FRAC_W  = 4,
  parameter int BOUND_W = 11,
  parameter int CNT_W   = 16,
  localparam int DIFF_W = COORD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_addr_i,
  input  logic [COORD_W-1:0] cfg_wdata_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [COORD_W-1:0] in_x_i,
  input  logic [COORD_W-1:0] in_y_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [BOUND_W-1:0] out_x_o,
  output logic [BOUND_W-1:0] out_y_o,
  output logic [CNT_W-1:0]   rej_cnt_o
);
  logic [COORD_W-1:0] off_x, off_y;
  logic [BOUND_W-1:0] min_x, max_x, min_y, max_y;
  logic               clr, adv, drop, s1_valid;
  logic [DIFF_W-1:0]  dx, dy;

  scis_cfg_regs #(.COORD_W(COORD_W), .BOUND_W(BOUND_W)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .off_x_o(off_x), .off_y_o(off_y), .min_x_o(min_x), .max_x_o(max_x),
    .min_y_o(min_y), .max_y_o(max_y), .clr_o(clr)
  );

  scis_sub_stage #(.COORD_W(COORD_W)) u_sub (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_x_i, .in_y_i,
    .off_x_i(off_x), .off_y_i(off_y), .adv_i(adv),
    .s1_valid_o(s1_valid), .dx_o(dx), .dy_o(dy)
  );

  scis_cmp_stage #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .BOUND_W(BOUND_W)) u_cmp (
    .clk_i, .rst_ni, .s1_valid_i(s1_valid), .dx_i(dx), .dy_i(dy),
    .min_x_i(min_x), .max_x_i(max_x), .min_y_i(min_y), .max_y_i(max_y),
    .adv_o(adv), .drop_o(drop), .out_valid_o, .out_ready_i, .out_x_o, .out_y_o
  );

  scis_rej_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(drop), .clr_i(clr), .cnt_o(rej_cnt_o)
  );
endmodule

// File: tb/pix_scissor_tb.sv
`timescale 1ns/1ps
module pix_scissor_tb;
  localparam int CW = 4;

  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [2:0]  cfg_addr_i = 0;
  logic [15:0] cfg_wdata_i = 0;
  logic        in_valid_i = 0, in_ready_o;
  logic [15:0] in_x_i = 0, in_y_i = 0;
  logic        out_valid_o, out_ready_i = 1;
  logic [10:0] out_x_o, out_y_o;
  logic [CW-1:0] rej_cnt_o;

  pix_scissor #(.CNT_W(CW)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int tests = 0, fails = 0, exp_rej = 0, pops = 0;
  logic bp_en = 0;
  logic [21:0] exp_q[$];
  logic [15:0] s_offx = 16'h8000, s_offy = 16'h8000;
  logic [10:0] s_mnx = 0, s_mxx = 2047, s_mny = 0, s_mxy = 2047;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // hit flag, then x, then y
  function automatic logic [22:0] model(input logic [15:0] x, y);
    logic [16:0] dx, dy;
    logic [11:0] ix, iy;
    logic hit;
    dx = {1'b0, x} - {1'b0, s_offx};
    dy = {1'b0, y} - {1'b0, s_offy};
    ix = dx[15:4];
    iy = dy[15:4];
    hit = !dx[16] && !dy[16] && ix >= {1'b0, s_mnx} && ix <= {1'b0, s_mxx}
          && iy >= {1'b0, s_mny} && iy <= {1'b0, s_mxy};
    return {hit, ix[10:0], iy[10:0]};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
    case (a)
      0: s_offx = d;       1: s_offy = d;
      2: s_mnx = d[10:0];  3: s_mxx = d[10:0];
      4: s_mny = d[10:0];  5: s_mxy = d[10:0];
      default: ;
    endcase
  endtask

  task automatic send(input logic [15:0] x, y);
    logic [22:0] m;
    logic rdy;
    in_valid_i = 1; in_x_i = x; in_y_i = y;
    forever begin
      rdy = in_ready_o;
      @(posedge clk_i);
      if (rdy) break;
      @(negedge clk_i);
    end
    m = model(x, y);
    if (m[22]) exp_q.push_back(m[21:0]);
    else exp_rej++;
    @(negedge clk_i);
    in_valid_i = 0;
  endtask

  task automatic drain();
    bp_en = 0;
    repeat (6) @(negedge clk_i);
  endtask

  // monitor: R1 R3 R6 R7 data and order against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) chk("R6 unexpected output", 1, 0);
      else begin
        logic [21:0] e;
        e = exp_q.pop_front();
        chk("R1/R3 out_x", int'(out_x_o), int'(e[21:11]));
        chk("R1/R3 out_y", int'(out_y_o), int'(e[10:0]));
      end
      pops++;
    end
  end

  always @(posedge clk_i) begin
    #1 out_ready_i = bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [15:0] fx(input int ip, input int fr);
    return 16'((ip << 4) | fr);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R5 reset state
    chk("R5 in_ready", int'(in_ready_o), 1);
    chk("R5 out_valid", int'(out_valid_o), 0);
    chk("R5 rej_cnt", int'(rej_cnt_o), 0);

    // R5 default offset 2048.0 and R6 latency
    send(fx(2053, 0), fx(2048, 8));
    chk("R6 not yet valid", int'(out_valid_o), 0);
    @(negedge clk_i);
    chk("R6 valid after 2 edges", int'(out_valid_o), 1);
    send(fx(4095, 15), fx(2048, 0));   // R5 default max 2047 passes
    send(fx(2047, 15), fx(2048, 0));   // R2 one sixteenth below offset
    drain();
    chk("R2/R8 count", int'(rej_cnt_o), 1);

    // R4 program offset and rectangle
    wr(0, fx(1000, 0)); wr(1, fx(500, 0));
    wr(2, 10); wr(3, 100); wr(4, 20); wr(5, 200);
    wr(6, 0);
    chk("R9 clear", int'(rej_cnt_o), 0);
    send(fx(1010, 0), fx(520, 0));     // R3 both minima, pass
    send(fx(1009, 15), fx(520, 0));    // R3 x below min
    send(fx(1100, 15), fx(700, 15));   // R1 truncation, both maxima
    send(fx(1101, 0), fx(600, 0));     // R3 x above max
    send(fx(1050, 0), fx(519, 15));    // R3 y below min
    send(fx(1050, 0), fx(701, 0));     // R3 y above max
    send(fx(999, 15), fx(600, 0));     // R2 x negative
    send(fx(1050, 0), fx(499, 0));     // R2 y negative
    drain();
    chk("R8 count of drops", int'(rej_cnt_o), 6);

    // R3 empty rectangle rejects all
    wr(6, 0);
    wr(2, 50); wr(3, 40);
    for (int i = 0; i < 3; i++) send(fx(1045, i), fx(600, 0));
    drain();
    chk("R3 empty rect drops", int'(rej_cnt_o), 3);

    // R8 saturation
    for (int i = 0; i < 20; i++) send(fx(1045, 0), fx(600, 0));
    drain();
    chk("R8 saturate", int'(rej_cnt_o), 15);
    wr(6, 0);
    chk("R9 clear after sat", int'(rej_cnt_o), 0);

    // R6 throughput: six back-to-back passing pixels
    wr(2, 0); wr(3, 2047); wr(4, 0); wr(5, 2047);
    begin
      int p0;
      p0 = pops;
      for (int i = 0; i < 6; i++) send(fx(1000 + i, 0), fx(500 + 2 * i, 3));
      repeat (2) @(negedge clk_i);
      chk("R6 one per cycle", pops - p0, 6);
    end

    // R6 R7 random pixels under random backpressure
    wr(2, 100); wr(3, 900); wr(4, 50); wr(5, 700);
    wr(6, 0);
    exp_rej = 0;
    bp_en = 1;
    for (int i = 0; i < 300; i++)
      send(16'(fx(900, 0) + ($urandom % 16'h4000)), 16'(fx(400, 0) + ($urandom % 16'h3800)));
    drain();
    chk("R8 random drops", int'(rej_cnt_o), exp_rej > 15 ? 15 : exp_rej);
    chk("R6 queue empty", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule